// File: doc/BRIEF.md
# Two-Times Interpolating Half-Band Filter for Complex Samples

This block doubles the sample rate of a complex baseband stream. Each accepted I/Q sample with the filter switched on yields two output samples on consecutive cycles. The first is the outer-tap phase of a fixed, symmetric, 11-position half-band response whose coefficients are 10-bit integers scaled so that 512 means unity. The second is the centre phase, which is exactly the input from two samples earlier, because the centre weight is unity. The polyphase split means the zero-weighted positions are never computed, and each mirrored pair of outer taps is added before its single multiply.

A mode input chooses between filtering and a straight bypass. In bypass every accepted sample comes out unchanged one cycle later, at the input rate. The history line keeps shifting in both modes, so a switch back to filtering uses the real past samples. The input side has a registered ready. It drops for exactly one cycle after each filtered acceptance, which limits the input to half the output rate. I and Q run on identical, independent datapaths that share one valid and ready timing.

Top module: `ihb_interp`

## Requirements
- R1: While reset is asserted and in the first cycle after it, out_valid is 0, out_i and out_q are 0, and in_ready is 1.
- R2: A sample accepted (in_valid and in_ready both 1) with filt_en=1 gives out_valid=1 in the next cycle. The output value is sat(floor((14*(x[n]+x[n-5]) - 66*(x[n-1]+x[n-4]) + 309*(x[n-2]+x[n-3]) + 256) / 512)), where x[n-k] is the k-th earlier accepted sample of the same lane and the history is zero after reset.
- R3: In the cycle after that, out_valid is 1 again and the output equals x[n-2] exactly.
- R4: in_ready is 0 in the cycle that follows a filtered acceptance, and 1 in every other cycle. An in_valid seen while in_ready is 0 is ignored: it changes neither the output nor the history.
- R5: Rounding is half-up. A sum whose low nine bits are exactly 256 rounds toward plus infinity (for example, +1792 gives 4 and -1792 gives -3).
- R6: A rounded result above 2^21-1 is output as 2^21-1, and one below -2^21 is output as -2^21.
- R7: A sample accepted with filt_en=0 appears unchanged on the output with out_valid=1 in the next cycle. in_ready stays 1, so one output comes per input.
- R8: Samples accepted in bypass still enter the history used by later filtered outputs.
- R9: The I and Q lanes compute independently with the same formula and identical timing.
- R10: When nothing is accepted and no centre phase is pending, out_valid is 0 in the next cycle.
- R11: The mode is taken at acceptance. A pending centre phase is emitted even if filt_en falls in the cycle between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| filt_en | input | 1 | 1 = interpolate and filter, 0 = bypass |
| in_valid | input | 1 | Input sample strobe |
| in_ready | output | 1 | Registered: block can accept a sample this cycle |
| in_i | input | 22 | Signed in-phase input |
| in_q | input | 22 | Signed quadrature input |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | 22 | Signed in-phase output |
| out_q | output | 22 | Signed quadrature output |

## Verification
Two functions can land in the same cycle. The first is the centre-phase emission owed to the previous filtered sample. The second is either a fresh in_valid, which must be ignored, or a fall of filt_en, which must not cancel the pending phase. The bench raises in_valid on random cycles and toggles filt_en at random, so both collisions happen often. It also drives in_valid in every pending cycle of the directed sequences. Each collision is judged by comparing that cycle's output with the stored x[n-2], and by checking that the next filtered output's history contains no trace of the dropped sample.

// File: rtl/ihb_pkg.sv
package ihb_pkg;
  // coefficient scale: 2**FRAC_BITS represents unity
  localparam int COEF_BITS = 10;
  localparam int FRAC_BITS = 9;
  // outer-phase weights, one per mirrored pair
  localparam int W_EDGE = 14;
  localparam int W_MID  = -66;
  localparam int W_NEAR = 309;
  // number of past samples the filter needs
  localparam int HIST = 5;
  // index of the history entry emitted as the centre phase
  localparam int CENTER_IDX = 2;
  localparam int LANES = 2;
endpackage

// File: rtl/ihb_tap_line.sv
module ihb_tap_line
  import ihb_pkg::*;
#(
  parameter int DW = 22
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shift_en,
  input  logic signed [DW-1:0] din,
  output logic signed [DW-1:0] taps [HIST]
);
  logic signed [DW-1:0] line_q [HIST];
  logic signed [DW-1:0] line_d [HIST];

  always_comb begin
    for (int k = 0; k < HIST; k++) line_d[k] = line_q[k];
    if (shift_en) begin
      line_d[0] = din;
      for (int k = 1; k < HIST; k++) line_d[k] = line_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < HIST; k++) line_q[k] <= '0;
    end else begin
      for (int k = 0; k < HIST; k++) line_q[k] <= line_d[k];
    end
  end

  always_comb begin
    for (int k = 0; k < HIST; k++) taps[k] = line_q[k];
  end
endmodule

// File: rtl/ihb_outer_phase.sv
module ihb_outer_phase
  import ihb_pkg::*;
#(
  parameter int DW = 22
) (
  input  logic signed [DW-1:0] x_new,
  input  logic signed [DW-1:0] taps [HIST],
  output logic signed [DW-1:0] y
);
  localparam int SW = DW + 1;
  localparam int AW = DW + COEF_BITS + 4;
  localparam logic signed [AW-1:0] K_EDGE = AW'(W_EDGE);
  localparam logic signed [AW-1:0] K_MID  = AW'(W_MID);
  localparam logic signed [AW-1:0] K_NEAR = AW'(W_NEAR);
  localparam logic signed [AW-1:0] HALF   = AW'(1 << (FRAC_BITS - 1));
  localparam logic signed [AW-1:0] Y_MAX  = AW'((1 << (DW - 1)) - 1);
  localparam logic signed [AW-1:0] Y_MIN  = -(AW'(1 << (DW - 1)));

  logic signed [SW-1:0] pair_edge, pair_mid, pair_near;
  logic signed [AW-1:0] prod_edge, prod_mid, prod_near;
  logic signed [AW-1:0] acc, scaled;

  // mirrored pairs are added first, so each pair costs one multiply
  always_comb begin
    pair_edge = SW'(x_new)   + SW'(taps[4]);
    pair_mid  = SW'(taps[0]) + SW'(taps[3]);
    pair_near = SW'(taps[1]) + SW'(taps[2]);
  end

  always_comb begin
    prod_edge = AW'(pair_edge) * K_EDGE;
    prod_mid  = AW'(pair_mid)  * K_MID;
    prod_near = AW'(pair_near) * K_NEAR;
    acc       = prod_edge + prod_mid + prod_near + HALF;
    scaled    = acc >>> FRAC_BITS;
  end

  always_comb begin
    if (scaled > Y_MAX)      y = Y_MAX[DW-1:0];
    else if (scaled < Y_MIN) y = Y_MIN[DW-1:0];
    else                     y = scaled[DW-1:0];
  end
endmodule

// File: rtl/ihb_phase_ctl.sv
module ihb_phase_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic filt_en,
  output logic take,
  output logic take_filt,
  output logic emit_center,
  output logic in_ready
);
  logic pend_q, pend_d;

  always_comb begin
    take        = in_valid && !pend_q;
    take_filt   = take && filt_en;
    emit_center = pend_q;
    pend_d      = take_filt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign in_ready = !pend_q;
endmodule

// File: rtl/ihb_interp.sv
module ihb_interp
  import ihb_pkg::*;
#(
  parameter int DW = 22
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 filt_en,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q
);
  logic take, take_filt, emit_center;
  logic signed [DW-1:0] lane_in  [LANES];
  logic signed [DW-1:0] lane_out [LANES];
  logic vld_q, vld_d;

  ihb_phase_ctl u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .filt_en     (filt_en),
    .take        (take),
    .take_filt   (take_filt),
    .emit_center (emit_center),
    .in_ready    (in_ready)
  );

  assign lane_in[0] = in_i;
  assign lane_in[1] = in_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic signed [DW-1:0] taps [HIST];
    logic signed [DW-1:0] outer;
    logic signed [DW-1:0] res_q, res_d;

    ihb_tap_line #(.DW(DW)) u_line (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (take),
      .din      (lane_in[g]),
      .taps     (taps)
    );

    ihb_outer_phase #(.DW(DW)) u_outer (
      .x_new (lane_in[g]),
      .taps  (taps),
      .y     (outer)
    );

    always_comb begin
      res_d = res_q;
      if (take_filt)        res_d = outer;
      else if (take)        res_d = lane_in[g];
      else if (emit_center) res_d = taps[CENTER_IDX];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) res_q <= '0;
      else        res_q <= res_d;
    end

    assign lane_out[g] = res_q;
  end

  always_comb vld_d = take || emit_center;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  assign out_valid = vld_q;
  assign out_i     = lane_out[0];
  assign out_q     = lane_out[1];
endmodule

// File: rtl/ihb_interp_chk.sv
module ihb_interp_chk #(
  parameter int DW = 22
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 filt_en,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic signed [DW-1:0] in_i,
  input logic signed [DW-1:0] in_q,
  input logic                 out_valid,
  input logic signed [DW-1:0] out_i,
  input logic signed [DW-1:0] out_q
);
  // R4: a filtered acceptance blocks the following cycle
  p_ready_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && filt_en) |=> !in_ready);

  // R2: first phase is presented one cycle after a filtered acceptance
  p_first_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && filt_en) |=> out_valid);

  // R3 / R11: a blocked cycle is always followed by the centre phase
  p_center_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> (out_valid && in_ready));

  // R7: bypass returns the sample unchanged and keeps accepting
  p_bypass_echo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !filt_en) |=>
      (out_valid && in_ready && out_i == $past(in_i) && out_q == $past(in_q)));

  // R10: no acceptance and nothing pending means no output
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && in_ready) |=> !out_valid);
endmodule

bind ihb_interp ihb_interp_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .filt_en   (filt_en),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_i      (in_i),
  .in_q      (in_q),
  .out_valid (out_valid),
  .out_i     (out_i),
  .out_q     (out_q)
);

// File: tb/tb_ihb_interp.sv
`timescale 1ns/1ps
module tb_ihb_interp;
  localparam int DW = 22;
  localparam longint VMAX = (64'sd1 <<< (DW-1)) - 1;
  localparam longint VMIN = -(64'sd1 <<< (DW-1));

  logic clk = 1'b0;
  logic rst_n;
  logic filt_en, in_valid, in_ready, out_valid;
  logic signed [DW-1:0] in_i, in_q, out_i, out_q;

  always #2 clk = ~clk;

  ihb_interp #(.DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .filt_en(filt_en), .in_valid(in_valid),
    .in_ready(in_ready), .in_i(in_i), .in_q(in_q),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  longint hi [5];
  longint hq [5];
  bit m_pend;
  int bp_age;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint acc_of(input longint x, input longint h [5]);
    return 14*(x + h[4]) - 66*(h[0] + h[3]) + 309*(h[1] + h[2]) + 256;
  endfunction

  function automatic longint sat(input longint v);
    if (v > VMAX) return VMAX;
    if (v < VMIN) return VMIN;
    return v;
  endfunction

  function automatic longint rnd_sample();
    int sel = $urandom_range(0, 7);
    if (sel == 0) return VMAX;
    if (sel == 1) return VMIN;
    return longint'($signed(DW'($urandom())));
  endfunction

  // one clock cycle: drive at negedge, compare at the following negedge
  task automatic cyc(input bit v, input bit en, input longint xi, input longint xq);
    bit    ev;
    longint ei, eq, ai, aq;
    string tag;
    ev = 0; ei = 0; eq = 0; tag = "R10";
    in_valid = v; filt_en = en;
    in_i = DW'(xi); in_q = DW'(xq);
    if (v && !m_pend) begin
      ev = 1;
      if (en) begin
        ai = acc_of(xi, hi); aq = acc_of(xq, hq);
        ei = sat(ai >>> 9); eq = sat(aq >>> 9);
        if (ei != (ai >>> 9) || eq != (aq >>> 9)) tag = "R6";
        else if ((ai & 511) == 256 || (aq & 511) == 256) tag = "R5";
        else if (bp_age > 0) tag = "R8";
        else tag = "R2";
        if (bp_age > 0) bp_age--;
        m_pend = 1;
      end else begin
        ei = xi; eq = xq; tag = "R7"; bp_age = 5;
      end
      for (int k = 4; k > 0; k--) begin hi[k] = hi[k-1]; hq[k] = hq[k-1]; end
      hi[0] = xi; hq[0] = xq;
    end else if (m_pend) begin
      ev = 1; ei = hi[2]; eq = hq[2];
      tag = !en ? "R11" : (v ? "R4" : "R3");
      m_pend = 0;
    end
    @(posedge clk);
    @(negedge clk);
    chk(out_valid == ev, tag, longint'(out_valid), longint'(ev));
    chk(in_ready == !m_pend, "R4", longint'(in_ready), longint'(!m_pend));
    if (ev) begin
      chk(longint'(out_i) == ei, tag, longint'(out_i), ei);
      chk(longint'(out_q) == eq, $sformatf("%s R9", tag), longint'(out_q), eq);
    end
  endtask

  // accept one sample; in filtered mode also run the centre cycle with a stray strobe
  task automatic feed(input bit en, input longint xi, input longint xq);
    cyc(1'b1, en, xi, xq);
    if (en) cyc(1'b1, en, rnd_sample(), rnd_sample());
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    for (int k = 0; k < 5; k++) begin hi[k] = 0; hq[k] = 0; end
    m_pend = 0; bp_age = 0;
    rst_n = 1'b0; filt_en = 1'b1; in_valid = 1'b0; in_i = '0; in_q = '0;
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && in_ready == 1, "R1", longint'({out_valid, in_ready}), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 0, "R1", longint'(out_valid), 0);
    chk(out_i == 0 && out_q == 0, "R1", longint'(out_i), 0);
    chk(in_ready == 1, "R1", longint'(in_ready), 1);

    // R5: half-up rounding, positive and negative ties
    for (int k = 0; k < 5; k++) feed(1'b1, 0, 0);
    feed(1'b1, 128, -128);
    for (int k = 0; k < 5; k++) feed(1'b1, 0, 0);
    feed(1'b1, -128, 128);

    // R6: positive saturation on I, negative on Q
    feed(1'b1, VMAX, VMIN); feed(1'b1, VMIN, VMAX); feed(1'b1, VMAX, VMIN);
    feed(1'b1, VMAX, VMIN); feed(1'b1, VMIN, VMAX); feed(1'b1, VMAX, VMIN);

    // R7 then R8: bypass run, then back to filtering
    for (int k = 0; k < 4; k++) feed(1'b0, rnd_sample(), rnd_sample());
    cyc(1'b0, 1'b0, 0, 0);
    for (int k = 0; k < 3; k++) feed(1'b1, rnd_sample(), rnd_sample());

    // R11: mode falls while the centre phase is pending
    cyc(1'b1, 1'b1, 1000, -2000);
    cyc(1'b1, 1'b0, 7, 9);
    cyc(1'b1, 1'b0, 11, 13);

    // random mix of all behaviours
    begin
      bit en = 1'b1;
      for (int n = 0; n < 4000; n++) begin
        if ($urandom_range(0, 15) == 0) en = !en;
        cyc($urandom_range(0, 3) != 0, en, rnd_sample(), rnd_sample());
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule